// File: doc/BRIEF.md
# Byte-Aliased General Register File

This block holds a small set of general registers, each 32 bits wide, that can be reached at three widths: the whole register, its low 16 bits, or either byte of that low half. The narrower views are windows onto the same storage, not separate registers. A write at byte or half width merges into the register and leaves every bit it does not address as it was. A read at a narrow width returns that window of the current contents.

There is one write port and two independent combinational read ports. Every port names a register by index and gives an access width. When the width is byte, a half-select bit picks the upper or the lower byte of the low 16 bits. A datapath uses the block as an operand store: it reads two operands in the same cycle and writes one result at the end of the cycle.

Top module: `aliased_regfile`

## Requirements
- R1: A synchronous active-high reset sets every bit of every register to zero.
- R2: A write with width code 2'b10 replaces all 32 bits of the addressed register with wdata.
- R3: A write with width code 2'b00 and half-select 0 puts wdata[7:0] into bits 7:0 and leaves bits 31:8 unchanged.
- R4: A write with width code 2'b00 and half-select 1 puts wdata[7:0] into bits 15:8 and leaves bits 31:16 and 7:0 unchanged.
- R5: A write with width code 2'b01 puts wdata[15:0] into bits 15:0, which changes both byte views, and leaves bits 31:16 unchanged.
- R6: Reads work as follows. Width 2'b00 with half-select 0 returns bits 7:0, zero-extended. Width 2'b00 with half-select 1 returns bits 15:8, zero-extended. Width 2'b01 returns bits 15:0, zero-extended. Width 2'b10 returns all 32 bits.
- R7: The two read ports use the same encoding and work independently. Each can address any register in the same cycle as the other.
- R8: A write changes only the register selected by wsel. When we is low, no register changes.
- R9: Width code 2'b11 is reserved. A write with it changes nothing, and a read with it returns zero.
- R10: When a read and a write address the same register in the same cycle, the read returns the value held before the clock edge. The new value is visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Write enable |
| wsel | input | $clog2(NREGS) | Register index for the write |
| wwidth | input | 2 | Write width code |
| whi | input | 1 | Upper-byte select for byte writes |
| wdata | input | DW | Write data |
| rsel_a | input | $clog2(NREGS) | Register index, read port A |
| rwidth_a | input | 2 | Width code, read port A |
| rhi_a | input | 1 | Upper-byte select, read port A |
| rdata_a | output | DW | Read data, port A |
| rsel_b | input | $clog2(NREGS) | Register index, read port B |
| rwidth_b | input | 2 | Width code, read port B |
| rhi_b | input | 1 | Upper-byte select, read port B |
| rdata_b | output | DW | Read data, port B |

## Verification
The bench builds the block with the default parameters: four registers of 32 bits. At that size every combination of register, width code and half-select can be written. After each write, every view of every register is read back on both ports. This exposes any merge that touches a neighbouring byte, a neighbouring register or the upper half. It also covers the reserved width code, a write with enable low, and a same-cycle read of the register being written.

// File: rtl/aliased_regfile.sv
module aliased_regfile #(
  parameter int NREGS = 4,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(NREGS)-1:0] wsel,
  input  logic [1:0]               wwidth,
  input  logic                     whi,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(NREGS)-1:0] rsel_a,
  input  logic [1:0]               rwidth_a,
  input  logic                     rhi_a,
  output logic [DW-1:0]            rdata_a,
  input  logic [$clog2(NREGS)-1:0] rsel_b,
  input  logic [1:0]               rwidth_b,
  input  logic                     rhi_b,
  output logic [DW-1:0]            rdata_b
);
  localparam int IW = $clog2(NREGS);
  localparam logic [1:0] W_BYTE = 2'b00;
  localparam logic [1:0] W_HALF = 2'b01;
  localparam logic [1:0] W_FULL = 2'b10;

  logic [NREGS-1:0][DW-1:0] regs;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                          input logic [1:0] w, input logic h,
                                          input logic [DW-1:0] d);
    logic [DW-1:0] n;
    n = old;
    case (w)
      W_BYTE: if (h) n[15:8] = d[7:0]; else n[7:0] = d[7:0];
      W_HALF: n[15:0] = d[15:0];
      W_FULL: n = d;
      default: ;
    endcase
    return n;
  endfunction

  function automatic logic [DW-1:0] view(input logic [DW-1:0] v,
                                         input logic [1:0] w, input logic h);
    case (w)
      W_BYTE:  return h ? {{(DW-8){1'b0}}, v[15:8]} : {{(DW-8){1'b0}}, v[7:0]};
      W_HALF:  return {{(DW-16){1'b0}}, v[15:0]};
      W_FULL:  return v;
      default: return '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREGS; i++) begin
      if (rst)
        regs[i] <= '0;
      else if (we && wsel == IW'(i))
        regs[i] <= merge(regs[i], wwidth, whi, wdata);
    end
  end

  assign rdata_a = view(regs[rsel_a], rwidth_a, rhi_a);
  assign rdata_b = view(regs[rsel_b], rwidth_b, rhi_b);
endmodule

// File: rtl/aliased_regfile_chk.sv
module aliased_regfile_chk #(
  parameter int NREGS = 4,
  parameter int DW    = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     we,
  input logic [$clog2(NREGS)-1:0] wsel,
  input logic [1:0]               wwidth,
  input logic                     whi,
  input logic [DW-1:0]            wdata,
  input logic [1:0]               rwidth_a,
  input logic [DW-1:0]            rdata_a,
  input logic [NREGS-1:0][DW-1:0] regs
);
  localparam int IW = $clog2(NREGS);

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) && rwidth_a == 2'b10 |-> rdata_a == '0);

  a_r6_byte_zext: assert property (@(posedge clk) disable iff (rst)
    rwidth_a == 2'b00 |-> rdata_a[DW-1:8] == '0);

  a_r9_reserved_read: assert property (@(posedge clk) disable iff (rst)
    rwidth_a == 2'b11 |-> rdata_a == '0);

  a_r3_low_byte_merge: assert property (@(posedge clk) disable iff (rst)
    we && wwidth == 2'b00 && !whi |=>
      regs[$past(wsel)][7:0] == $past(wdata[7:0]) &&
      regs[$past(wsel)][DW-1:8] == $past(regs[wsel][DW-1:8]));

  a_r4_high_byte_merge: assert property (@(posedge clk) disable iff (rst)
    we && wwidth == 2'b00 && whi |=>
      regs[$past(wsel)][15:8] == $past(wdata[7:0]) &&
      regs[$past(wsel)][7:0] == $past(regs[wsel][7:0]) &&
      regs[$past(wsel)][DW-1:16] == $past(regs[wsel][DW-1:16]));

  a_r5_half_keeps_upper: assert property (@(posedge clk) disable iff (rst)
    we && wwidth == 2'b01 |=>
      regs[$past(wsel)][15:0] == $past(wdata[15:0]) &&
      regs[$past(wsel)][DW-1:16] == $past(regs[wsel][DW-1:16]));

  a_r2_full_write: assert property (@(posedge clk) disable iff (rst)
    we && wwidth == 2'b10 |=> regs[$past(wsel)] == $past(wdata));

  a_r9_reserved_write: assert property (@(posedge clk) disable iff (rst)
    we && wwidth == 2'b11 |=> $stable(regs));

  for (genvar i = 0; i < NREGS; i++) begin : g_keep
    a_r8_others_stable: assert property (@(posedge clk) disable iff (rst)
      !we || wsel != IW'(i) |=> $stable(regs[i]));
  end
endmodule

bind aliased_regfile aliased_regfile_chk #(.NREGS(NREGS), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .we(we), .wsel(wsel), .wwidth(wwidth), .whi(whi),
  .wdata(wdata), .rwidth_a(rwidth_a), .rdata_a(rdata_a), .regs(regs)
);

// File: tb/tb_aliased_regfile.sv
`timescale 1ns/1ps
module tb_aliased_regfile;
  localparam int NREGS = 4;
  localparam int DW    = 32;
  localparam int IW    = $clog2(NREGS);

  logic clk = 1'b0;
  logic rst, we, whi, rhi_a, rhi_b;
  logic [IW-1:0] wsel, rsel_a, rsel_b;
  logic [1:0] wwidth, rwidth_a, rwidth_b;
  logic [DW-1:0] wdata, rdata_a, rdata_b;

  int vectors = 0;
  int errors  = 0;
  logic [DW-1:0] model [NREGS];
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  aliased_regfile #(.NREGS(NREGS), .DW(DW)) dut (
    .clk(clk), .rst(rst), .we(we), .wsel(wsel), .wwidth(wwidth), .whi(whi),
    .wdata(wdata), .rsel_a(rsel_a), .rwidth_a(rwidth_a), .rhi_a(rhi_a),
    .rdata_a(rdata_a), .rsel_b(rsel_b), .rwidth_b(rwidth_b), .rhi_b(rhi_b),
    .rdata_b(rdata_b)
  );

  function automatic logic [DW-1:0] exp_view(input logic [DW-1:0] v, input int w, input int h);
    if (w == 0) return h != 0 ? DW'((v >> 8) % 256) : DW'(v % 256);
    if (w == 1) return DW'(v % 65536);
    if (w == 2) return v;
    return '0;
  endfunction

  function automatic logic [DW-1:0] exp_write(input logic [DW-1:0] old, input int w,
                                              input int h, input logic [DW-1:0] d);
    logic [DW-1:0] lo8;
    lo8 = DW'(d % 256);
    if (w == 0 && h == 0) return (old & ~DW'(32'hFF)) | lo8;
    if (w == 0)           return (old & ~DW'(32'hFF00)) | (lo8 * 256);
    if (w == 1)           return (old & ~DW'(32'hFFFF)) | DW'(d % 65536);
    if (w == 2)           return d;
    return old;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string wreq, input int wr);
    for (int r = 0; r < NREGS; r++)
      for (int w = 0; w < 4; w++)
        for (int h = 0; h < 2; h++) begin
          rsel_a = IW'(r); rwidth_a = 2'(w); rhi_a = h[0];
          rsel_b = IW'((r + 1) % NREGS); rwidth_b = 2'(w); rhi_b = h[0];
          #0.1;
          check(r == wr ? wreq : (w == 3 ? "R9" : "R6"), rdata_a, exp_view(model[r], w, h));
          check("R7", rdata_b, exp_view(model[(r + 1) % NREGS], w, h));
        end
  endtask

  task automatic do_write(input int r, input int w, input int h, input logic [DW-1:0] d);
    @(negedge clk);
    we = 1'b1; wsel = IW'(r); wwidth = 2'(w); whi = h[0]; wdata = d;
    @(negedge clk);
    we = 1'b0;
    model[r] = exp_write(model[r], w, h, d);
  endtask

  function automatic string wreq_of(input int w, input int h);
    if (w == 0) return h != 0 ? "R4" : "R3";
    if (w == 1) return "R5";
    if (w == 2) return "R2";
    return "R9";
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int r = 0; r < NREGS; r++) model[r] = '0;
    check_all("R1", 0);
  endtask

  initial begin
    rst = 1'b1; we = 1'b0; wsel = '0; wwidth = '0; whi = 1'b0; wdata = '0;
    rsel_a = '0; rwidth_a = '0; rhi_a = 1'b0; rsel_b = '0; rwidth_b = '0; rhi_b = 1'b0;
    do_reset();
    for (int r = 0; r < NREGS; r++) do_write(r, 2, 0, 32'hA5A5_0000 + 32'(r * 32'h1111));
    check_all("R2", 0);
    for (int r = 0; r < NREGS; r++)
      for (int w = 0; w < 4; w++)
        for (int h = 0; h < 2; h++) begin
          seed = seed * 32'd1664525 + 32'd1013904223;
          do_write(r, w, h, seed);
          check_all(wreq_of(w, h), r);
        end
    // R8: enable low with live write inputs changes nothing
    @(negedge clk);
    we = 1'b0; wsel = 2'd1; wwidth = 2'b10; wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    check_all("R8", -1);
    // R10: same-cycle read of the register being written
    @(negedge clk);
    we = 1'b1; wsel = 2'd2; wwidth = 2'b10; whi = 1'b0; wdata = 32'h0BAD_F00D;
    rsel_a = 2'd2; rwidth_a = 2'b10; rhi_a = 1'b0;
    #0.1 check("R10", rdata_a, model[2]);
    @(posedge clk); #1;
    we = 1'b0;
    model[2] = 32'h0BAD_F00D;
    check("R10", rdata_a, model[2]);
    do_reset();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule